// File: doc/BRIEF.md
# Network Controller Register Window Decoder

This block sits between a host bus and a network controller. It decodes two address spaces, an I/O window and a memory-mapped window. Each window is 32 bytes wide. The lower half is a 16-byte station address PROM held inside the block. The upper half is forwarded to the controller's internal registers through a simple request/response register port.

The host presents one access at a time. An access carries a space select, an address, a size code (0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = reserved), a write flag and write data, and is held until `bus_wait_o` is low. PROM and unsupported accesses complete in the cycle they are presented. Register-port accesses stall the bus until the controller answers. Multi-byte PROM accesses in the memory-mapped window are built from single bytes, little-endian. The PROM is loaded at reset with a parameterised 48-bit station address and fill bytes. It can be rewritten only while the write-enable pin is high.

Top module: `nic_window_decoder`

## Requirements
- R1: After reset, PROM byte k (k = 0..5) holds bits [8k+7:8k] of STATION_ADDR, and bytes 6..15 hold FILL_BYTE. No register-port request and no bus wait are raised while idle.
- R2: With bus_mmio_i = 0, a byte access at address 0..15 reaches PROM byte addr[3:0], with no wait. Read data is that byte in bits [7:0] and zeros above.
- R3: With bus_mmio_i = 0, a 16-bit or 32-bit access at address 16..31 issues a register-port request. The request carries offset addr[3:0], rp_dword_o = 1 for 32-bit and 0 for 16-bit, the write flag, and write data masked to the access width.
- R4: An access in the I/O window that matches neither R2 nor R3 completes without wait and without a register-port request. Such accesses include any size-3 access in either window. A read returns all ones at the access width: 0xFF, 0xFFFF, or 0xFFFFFFFF for size 2 or 3. A write changes no PROM byte.
- R5: A PROM write takes effect only if prom_we_en_i is high in the completing cycle. Otherwise the PROM keeps its contents.
- R6: With bus_mmio_i = 1 and addr[4] = 1, a 16-bit or 32-bit access issues a register-port request with offset addr[3:0] and the same fields as R3.
- R7: With bus_mmio_i = 1 and addr[4] = 1, a byte access issues no request, completes without wait, returns 0xFF on read and is dropped on write.
- R8: With bus_mmio_i = 1 and addr[4] = 0, an access of N bytes (1, 2 or 4) covers PROM bytes (addr+i) mod 16, i = 0..N-1, with byte i in data bits [8i+7:8i]. On write, each byte is gated as in R5.
- R9: A register-port request holds rp_valid_o and its fields until rp_ready_i is high. After acceptance it drops rp_valid_o and keeps bus_wait_o high until rp_rsp_valid_i arrives, at least one cycle after acceptance. In that cycle bus_wait_o is low and a read returns rp_rdata_i masked to the access width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prom_we_en_i | input | 1 | PROM write enable from configuration |
| bus_valid_i | input | 1 | Access present, held while bus_wait_o is high |
| bus_mmio_i | input | 1 | 0 = I/O window, 1 = memory-mapped window |
| bus_addr_i | input | 5 | Byte address within the window |
| bus_size_i | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| bus_we_i | input | 1 | Write access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid when bus_wait_o is low |
| bus_wait_o | output | 1 | Stall the bus |
| rp_valid_o | output | 1 | Register-port request valid |
| rp_ready_i | input | 1 | Register-port request accepted |
| rp_off_o | output | 4 | Register offset |
| rp_dword_o | output | 1 | 1 = 32-bit, 0 = 16-bit |
| rp_we_o | output | 1 | Register write |
| rp_wdata_o | output | 32 | Register write data, width-masked |
| rp_rsp_valid_i | input | 1 | Register-port response strobe |
| rp_rdata_i | input | 32 | Register-port read data |

## Verification
The hardest case to reach is a 32-bit memory-mapped PROM write whose bytes wrap from offset 15 back to 0. The bench writes at offset 14, then reads the result back both as a wrapped 32-bit word and as single I/O bytes at offsets 0 and 1. Register-port accesses run with several ready and response delays, so the request hold and the wait release are seen at each stage. Gated and unmatched writes are followed by PROM reads of the bytes they could have touched.

// File: rtl/nic_win_pkg.sv
package nic_win_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PROM = 2'd1,
    TGT_PORT = 2'd2
  } target_e;
endpackage

// File: rtl/nic_win_decode.sv
module nic_win_decode
  import nic_win_pkg::*;
#(
  parameter int OFF_W = 4,
  parameter int LANES = 4
) (
  input  logic             mmio_i,
  input  logic [OFF_W:0]   addr_i,
  input  logic [1:0]       size_i,
  output target_e          tgt_o,
  output logic [LANES-1:0] lanes_o
);
  acc_size_e sz;
  logic      upper;

  assign sz    = acc_size_e'(size_i);
  assign upper = addr_i[OFF_W];

  always_comb begin
    tgt_o = TGT_NONE;
    if (sz != SZ_RSVD) begin
      if (!mmio_i) begin
        if (!upper && sz == SZ_BYTE)      tgt_o = TGT_PROM;
        else if (upper && sz != SZ_BYTE)  tgt_o = TGT_PORT;
      end else begin
        if (!upper)                       tgt_o = TGT_PROM;
        else if (sz != SZ_BYTE)           tgt_o = TGT_PORT;
      end
    end
  end

  always_comb begin
    case (sz)
      SZ_BYTE: lanes_o = LANES'(1);
      SZ_WORD: lanes_o = LANES'(3);
      default: lanes_o = '1;
    endcase
  end
endmodule

// File: rtl/nic_win_prom.sv
module nic_win_prom #(
  parameter int          BYTES        = 16,
  parameter int          LANES        = 4,
  parameter logic [47:0] STATION_ADDR = 48'h0,
  parameter logic [7:0]  FILL_BYTE    = 8'h57,
  localparam int         OFF_W        = $clog2(BYTES),
  localparam int         SA_BYTES     = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [OFF_W-1:0]     base_i,
  input  logic [LANES-1:0]     lanes_i,
  input  logic                 wr_i,
  input  logic [8*LANES-1:0]   wdata_i,
  output logic [8*LANES-1:0]   rdata_o,
  output logic [8*BYTES-1:0]   flat_o
);
  logic [7:0]       mem_q [BYTES];
  logic [OFF_W-1:0] idx   [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // index wraps naturally in OFF_W bits
    assign idx[k] = base_i + OFF_W'(k);
    assign rdata_o[8*k +: 8] = lanes_i[k] ? mem_q[idx[k]] : 8'h00;
  end

  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    localparam logic [7:0] INIT = (j < SA_BYTES) ? STATION_ADDR[8*j +: 8] : FILL_BYTE;
    assign flat_o[8*j +: 8] = mem_q[j];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[j] <= INIT;
      end else if (wr_i) begin
        for (int k = 0; k < LANES; k++) begin
          if (lanes_i[k] && idx[k] == OFF_W'(j)) mem_q[j] <= wdata_i[8*k +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/nic_win_port.sv
module nic_win_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ready_i,
  input  logic rsp_i,
  output logic valid_o,
  output logic wait_o
);
  logic pending_q;

  assign valid_o = req_i && !pending_q;
  assign wait_o  = req_i && !(pending_q && rsp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pending_q <= 1'b0;
    else if (valid_o && ready_i)     pending_q <= 1'b1;
    else if (pending_q && rsp_i)     pending_q <= 1'b0;
  end
endmodule

// File: rtl/nic_window_decoder.sv
module nic_window_decoder
  import nic_win_pkg::*;
#(
  parameter int          PROM_BYTES   = 16,
  parameter int          DATA_W       = 32,
  parameter logic [47:0] STATION_ADDR = 48'h66_55_44_33_22_11,
  parameter logic [7:0]  FILL_BYTE    = 8'h57,
  localparam int         OFF_W        = $clog2(PROM_BYTES),
  localparam int         AW           = OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prom_we_en_i,
  input  logic              bus_valid_i,
  input  logic              bus_mmio_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [1:0]        bus_size_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_wait_o,
  output logic              rp_valid_o,
  input  logic              rp_ready_i,
  output logic [OFF_W-1:0]  rp_off_o,
  output logic              rp_dword_o,
  output logic              rp_we_o,
  output logic [DATA_W-1:0] rp_wdata_o,
  input  logic              rp_rsp_valid_i,
  input  logic [DATA_W-1:0] rp_rdata_i
);
  localparam int LANES = DATA_W / 8;

  target_e                 tgt;
  logic [LANES-1:0]        lanes;
  logic [DATA_W-1:0]       width_mask;
  logic [DATA_W-1:0]       prom_rdata;
  logic [8*PROM_BYTES-1:0] prom_flat;
  logic                    prom_wr;
  logic                    port_req;

  nic_win_decode #(.OFF_W(OFF_W), .LANES(LANES)) u_dec (
    .mmio_i  (bus_mmio_i),
    .addr_i  (bus_addr_i),
    .size_i  (bus_size_i),
    .tgt_o   (tgt),
    .lanes_o (lanes)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign width_mask[8*k +: 8] = {8{lanes[k]}};
  end

  assign prom_wr = bus_valid_i && bus_we_i && prom_we_en_i && (tgt == TGT_PROM);

  nic_win_prom #(
    .BYTES        (PROM_BYTES),
    .LANES        (LANES),
    .STATION_ADDR (STATION_ADDR),
    .FILL_BYTE    (FILL_BYTE)
  ) u_prom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .base_i  (bus_addr_i[OFF_W-1:0]),
    .lanes_i (lanes),
    .wr_i    (prom_wr),
    .wdata_i (bus_wdata_i),
    .rdata_o (prom_rdata),
    .flat_o  (prom_flat)
  );

  assign port_req = bus_valid_i && (tgt == TGT_PORT);

  nic_win_port u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (port_req),
    .ready_i (rp_ready_i),
    .rsp_i   (rp_rsp_valid_i),
    .valid_o (rp_valid_o),
    .wait_o  (bus_wait_o)
  );

  assign rp_off_o   = bus_addr_i[OFF_W-1:0];
  assign rp_dword_o = (acc_size_e'(bus_size_i) == SZ_DWORD);
  assign rp_we_o    = bus_we_i;
  assign rp_wdata_o = bus_wdata_i & width_mask;

  always_comb begin
    case (tgt)
      TGT_PROM: bus_rdata_o = prom_rdata;
      TGT_PORT: bus_rdata_o = rp_rdata_i & width_mask;
      default:  bus_rdata_o = width_mask;
    endcase
  end
endmodule

// File: rtl/nic_win_chk.sv
module nic_win_chk #(
  parameter int PROM_BYTES = 16,
  parameter int DATA_W     = 32,
  parameter int AW         = 5,
  parameter int OFF_W      = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    prom_we_en_i,
  input logic                    bus_valid_i,
  input logic                    bus_mmio_i,
  input logic [AW-1:0]           bus_addr_i,
  input logic [1:0]              bus_size_i,
  input logic                    bus_we_i,
  input logic [DATA_W-1:0]       bus_rdata_o,
  input logic                    bus_wait_o,
  input logic                    rp_valid_o,
  input logic                    rp_ready_i,
  input logic [OFF_W-1:0]        rp_off_o,
  input logic [DATA_W-1:0]       rp_wdata_o,
  input logic [8*PROM_BYTES-1:0] prom_flat
);
  // R5
  prom_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prom_we_en_i |=> $stable(prom_flat));

  // R2
  io_prom_nowait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_mmio_i && bus_size_i == 2'd0 && !bus_addr_i[AW-1])
      |-> (!bus_wait_o && !rp_valid_o));

  // R7
  mmio_reg_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_mmio_i && bus_size_i == 2'd0 && bus_addr_i[AW-1])
      |-> (!rp_valid_o && !bus_wait_o && (bus_we_i || bus_rdata_o == DATA_W'(8'hFF))));

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rp_valid_o && !rp_ready_i) |=> (rp_valid_o && $stable(rp_off_o) && $stable(rp_wdata_o)));

  // R9
  no_reissue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rp_valid_o && rp_ready_i) |=> !rp_valid_o);

  // R9
  wait_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wait_o |-> bus_valid_i);
endmodule

bind nic_window_decoder nic_win_chk #(
  .PROM_BYTES (PROM_BYTES),
  .DATA_W     (DATA_W),
  .AW         (AW),
  .OFF_W      (OFF_W)
) u_chk (.*);

// File: tb/sim_nic_window_decoder.sv
module sim_nic_window_decoder;
  localparam int          CLK_PERIOD = 10;
  localparam logic [47:0] MAC        = 48'h66_55_44_33_22_11;
  localparam logic [7:0]  FILL       = 8'h57;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prom_we_en = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_mmio = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wait;
  logic        rp_valid;
  logic        rp_ready = 1'b0;
  logic [3:0]  rp_off;
  logic        rp_dword;
  logic        rp_we;
  logic [31:0] rp_wdata;
  logic        rp_rsp = 1'b0;
  logic [31:0] rp_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] prom_m [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_window_decoder #(.STATION_ADDR(MAC), .FILL_BYTE(FILL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .prom_we_en_i(prom_we_en),
    .bus_valid_i(bus_valid), .bus_mmio_i(bus_mmio), .bus_addr_i(bus_addr),
    .bus_size_i(bus_size), .bus_we_i(bus_we), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .bus_wait_o(bus_wait),
    .rp_valid_o(rp_valid), .rp_ready_i(rp_ready), .rp_off_o(rp_off),
    .rp_dword_o(rp_dword), .rp_we_o(rp_we), .rp_wdata_o(rp_wdata),
    .rp_rsp_valid_i(rp_rsp), .rp_rdata_i(rp_rdata)
  );

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: act=running exp=finished");
    summary_and_end();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int kind_of(input bit sp, input logic [4:0] a, input logic [1:0] sz);
    if (sz == 2'd3) return 0;
    if (!sp) begin
      if (!a[4] && sz == 2'd0) return 1;
      if (a[4] && sz != 2'd0)  return 2;
      return 0;
    end
    if (a[4]) return (sz == 2'd0) ? 0 : 2;
    return 1;
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ones(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] prom_read(input logic [4:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int k = 0; k < nbytes(sz); k++) v[8*k +: 8] = prom_m[(int'(a[3:0]) + k) % 16];
    return v;
  endfunction

  // One bus access; ready after rdy_dly cycles, response rsp_dly cycles later
  task automatic access(input string req, input bit sp, input logic [4:0] a,
                        input logic [1:0] sz, input bit we, input logic [31:0] wd,
                        input int rdy_dly, input int rsp_dly);
    int kind = kind_of(sp, a, sz);
    logic [31:0] resp = 32'hC0DE_0000 | {27'd0, a};
    @(negedge clk);
    bus_valid = 1'b1; bus_mmio = sp; bus_addr = a; bus_size = sz;
    bus_we = we; bus_wdata = wd;
    if (kind == 2) begin
      for (int i = 0; i <= rdy_dly; i++) begin
        rp_ready = (i == rdy_dly);
        #2;
        chk({req, " rp_valid"}, {31'd0, rp_valid}, 32'd1);
        chk({req, " wait"}, {31'd0, bus_wait}, 32'd1);
        chk({req, " off"}, {28'd0, rp_off}, {28'd0, a[3:0]});
        chk({req, " dword"}, {31'd0, rp_dword}, {31'd0, sz == 2'd2});
        chk({req, " we"}, {31'd0, rp_we}, {31'd0, we});
        chk({req, " wdata"}, rp_wdata, wd & ones(sz));
        @(negedge clk);
        rp_ready = 1'b0;
      end
      for (int i = 0; i < rsp_dly; i++) begin
        #2;
        chk({req, " held rp_valid"}, {31'd0, rp_valid}, 32'd0);
        chk({req, " held wait"}, {31'd0, bus_wait}, 32'd1);
        @(negedge clk);
      end
      rp_rsp = 1'b1; rp_rdata = resp;
      #2;
      chk({req, " release wait"}, {31'd0, bus_wait}, 32'd0);
      if (!we) chk({req, " rdata"}, bus_rdata, resp & ones(sz));
    end else begin
      #2;
      chk({req, " wait"}, {31'd0, bus_wait}, 32'd0);
      chk({req, " rp_valid"}, {31'd0, rp_valid}, 32'd0);
      if (!we) chk({req, " rdata"}, bus_rdata, (kind == 1) ? prom_read(a, sz) : ones(sz));
      if (we && kind == 1 && prom_we_en)
        for (int k = 0; k < nbytes(sz); k++)
          prom_m[(int'(a[3:0]) + k) % 16] = wd[8*k +: 8];
    end
    @(negedge clk);
    bus_valid = 1'b0; rp_rsp = 1'b0;
    #2;
    chk({req, " idle"}, {30'd0, bus_wait, rp_valid}, 32'd0);
  endtask

  initial begin
    for (int j = 0; j < 16; j++) prom_m[j] = (j < 6) ? MAC[8*j +: 8] : FILL;
    #(CLK_PERIOD * 2 + 3);
    chk("R1 reset wait", {31'd0, bus_wait}, 32'd0);
    chk("R1 reset rp_valid", {31'd0, rp_valid}, 32'd0);
    rst_n = 1'b1;

    // R1 R2: reset contents through I/O byte reads
    for (int j = 0; j < 16; j++) access("R1 R2 io byte read", 0, 5'(j), 2'd0, 0, 0, 0, 0);

    // R5: gated and enabled PROM writes
    prom_we_en = 1'b0;
    access("R5 gated io write", 0, 5'd3, 2'd0, 1, 32'hAA, 0, 0);
    access("R5 gated readback", 0, 5'd3, 2'd0, 0, 0, 0, 0);
    prom_we_en = 1'b1;
    access("R5 enabled io write", 0, 5'd3, 2'd0, 1, 32'hAA, 0, 0);
    access("R5 enabled readback", 0, 5'd3, 2'd0, 0, 0, 0, 0);

    // R8: wrapped dword write and reads
    access("R8 mmio dword wrap write", 1, 5'd14, 2'd2, 1, 32'h4433_2211, 0, 0);
    access("R8 mmio dword wrap read", 1, 5'd14, 2'd2, 0, 0, 0, 0);
    access("R8 io byte 0 after wrap", 0, 5'd0, 2'd0, 0, 0, 0, 0);
    access("R8 io byte 1 after wrap", 0, 5'd1, 2'd0, 0, 0, 0, 0);
    access("R8 mmio word read", 1, 5'd5, 2'd1, 0, 0, 0, 0);
    access("R8 mmio byte write", 1, 5'd9, 2'd0, 1, 32'h3C, 0, 0);
    access("R8 mmio byte read", 1, 5'd9, 2'd0, 0, 0, 0, 0);
    prom_we_en = 1'b0;
    access("R5 R8 gated mmio word write", 1, 5'd8, 2'd1, 1, 32'hBEEF, 0, 0);
    access("R5 R8 gated mmio readback", 1, 5'd8, 2'd1, 0, 0, 0, 0);
    prom_we_en = 1'b1;

    // R3 R9: I/O register port
    access("R3 R9 io word read", 0, 5'h12, 2'd1, 0, 0, 2, 3);
    access("R3 R9 io dword write", 0, 5'h1C, 2'd2, 1, 32'h1234_5678, 0, 1);
    access("R3 R9 io dword read", 0, 5'h10, 2'd2, 0, 0, 1, 0);

    // R4: unmatched I/O
    access("R4 io byte upper", 0, 5'h15, 2'd0, 0, 0, 0, 0);
    access("R4 io word lower", 0, 5'h04, 2'd1, 0, 0, 0, 0);
    access("R4 io dword lower", 0, 5'h00, 2'd2, 0, 0, 0, 0);
    access("R4 io rsvd size", 0, 5'h18, 2'd3, 0, 0, 0, 0);
    access("R4 mmio rsvd size", 1, 5'h02, 2'd3, 0, 0, 0, 0);
    access("R4 io word write lower", 0, 5'h04, 2'd1, 1, 32'hDEAD, 0, 0);
    access("R4 readback byte 4", 0, 5'h04, 2'd0, 0, 0, 0, 0);
    access("R4 readback byte 5", 0, 5'h05, 2'd0, 0, 0, 0, 0);

    // R6 R9: memory-mapped register port
    access("R6 R9 mmio word read", 1, 5'h16, 2'd1, 0, 0, 0, 2);
    access("R6 R9 mmio dword write", 1, 5'h10, 2'd2, 1, 32'hCAFE_F00D, 3, 0);

    // R7: memory-mapped byte to register half
    access("R7 mmio reg byte read", 1, 5'h13, 2'd0, 0, 0, 0, 0);
    access("R7 mmio reg byte write", 1, 5'h13, 2'd0, 1, 32'h77, 0, 0);

    // final full PROM compare
    for (int j = 0; j < 16; j++) access("R8 final io byte", 0, 5'(j), 2'd0, 0, 0, 0, 0);

    repeat (2) @(negedge clk);
    summary_and_end();
  end
endmodule